// File: doc/BRIEF.md
# Address-Decoding Control Bus Splitter

This block fans one register-access master out to a parameterised number of register slaves on a simple request/acknowledge control bus. A request carries write and read strobes, a 20-bit byte address, write data, byte enables, a timed-command flag and a timestamp. Each downstream port owns one window of the address space. The window is set at elaboration by a base address and an address-bit count N, and it covers 2**N bytes.

A request is steered only to the port whose window holds its address. That port sees the address with its base removed, so a slave always decodes from offset zero. Slave replies (acknowledge, status, read data) are merged back into one upstream reply. A request that falls in no window is answered by the block itself with an address-error status. Both paths are registered. The settings for each port come in two packed parameter vectors, with port 0 in the least significant slice: 20 bits per base and 32 bits per window width. Bases that are not aligned to their window size, and windows that overlap, stop elaboration.

Top module: `regbus_splitter`

## Requirements
- R1: A write or read strobe reaches port i only when the request address lies in [base_i, base_i + 2**N_i). Every other port's strobes stay low, and at most one port is strobed in any cycle.
- R2: The address presented to the selected port equals the request address minus that port's base.
- R3: Write data, byte enables, the timed-command flag and the timestamp reach the selected port unchanged.
- R4: Downstream strobes appear exactly one clock after the upstream request and last one cycle for a one-cycle request.
- R5: When exactly one slave acknowledges, the upstream acknowledge rises one clock later. Upstream status and read data are then taken from that slave alone, and fields from slaves that do not acknowledge have no effect.
- R6: A request that hits no window strobes no port. One clock later the block raises the upstream acknowledge with status 2'b11 (address error) and read data zero. Status 2'b00 means success.
- R7: A synchronous reset clears all downstream strobes and the upstream acknowledge. A request presented while reset is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_wr | input | 1 | Upstream write strobe |
| up_rd | input | 1 | Upstream read strobe |
| up_addr | input | 20 | Upstream byte address |
| up_data | input | 32 | Upstream write data |
| up_ben | input | 4 | Upstream byte enables |
| up_timed | input | 1 | Upstream timed-command flag |
| up_time | input | 64 | Upstream timestamp |
| up_ack | output | 1 | Merged acknowledge to the master |
| up_status | output | 2 | Merged status to the master |
| up_rdata | output | 32 | Merged read data to the master |
| dn_wr | output | NPORTS | Per-port write strobes |
| dn_rd | output | NPORTS | Per-port read strobes |
| dn_addr | output | 20*NPORTS | Per-port local offsets |
| dn_data | output | 32*NPORTS | Per-port write data |
| dn_ben | output | 4*NPORTS | Per-port byte enables |
| dn_timed | output | NPORTS | Per-port timed-command flags |
| dn_time | output | 64*NPORTS | Per-port timestamps |
| dn_ack | input | NPORTS | Per-port acknowledges |
| dn_status | input | 2*NPORTS | Per-port status |
| dn_rdata | input | 32*NPORTS | Per-port read data |

## Verification
Every address from 0x000 to 0x4FF is issued once, and writes and reads alternate in a pattern that differs between neighbouring windows. This tells apart the last byte of one window and the first byte of the next, and it shows whether a wrong base, window width or slice order has been used. The payload and reply data are derived from each address, and non-acknowledging slaves hold fixed non-zero garbage, so a lost rebase, a corrupted field or missing response gating each give a distinct mismatch. A few far addresses in the upper range confirm that the unmapped reply is produced, and requests overlapping reset confirm that they are dropped.

// File: rtl/rsplit_pkg.sv
package rsplit_pkg;
   localparam int ADDR_W = 20;
   localparam int DATA_W = 32;
   localparam int BEN_W  = 4;
   localparam int TIME_W = 64;
   localparam int STS_W  = 2;

   typedef enum logic [STS_W-1:0] {
      STS_OKAY     = 2'd0,
      STS_CMD_ERR  = 2'd1,
      STS_TIME_ERR = 2'd2,
      STS_ADDR_ERR = 2'd3
   } sts_e;
endpackage

// File: rtl/regbus_window.sv
// One address window: match on the incoming address, local offset on the held one.
module regbus_window
   import rsplit_pkg::*;
#(
   parameter logic [ADDR_W-1:0] BASE = '0,
   parameter int                AW   = 8
) (
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ADDR_W-1:0] held_addr,
   output logic              hit,
   output logic [ADDR_W-1:0] offset
);
   localparam logic [ADDR_W:0]   SPAN       = (ADDR_W+1)'(1) << AW;
   localparam logic [ADDR_W-1:0] LOCAL_MASK = ADDR_W'(SPAN - 1'b1);

   if (AW < 0 || AW > ADDR_W) begin : g_bad_width
      $error("window width %0d outside 0..%0d", AW, ADDR_W);
   end
   if ((BASE & LOCAL_MASK) != '0) begin : g_bad_align
      $error("base %h not aligned to a %0d-bit window", BASE, AW);
   end

   // Upper bits must equal the base; lower bits are free
   assign hit    = ((req_addr ^ BASE) & ~LOCAL_MASK) == '0;
   // Alignment makes subtracting the base identical to masking it off
   assign offset = held_addr & LOCAL_MASK;
endmodule

// File: rtl/regbus_req_stage.sv
// Request register: per-port strobes, one shared payload copy fanned out.
module regbus_req_stage
   import rsplit_pkg::*;
#(
   parameter int NPORTS = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     up_wr,
   input  logic                     up_rd,
   input  logic [NPORTS-1:0]        hit_vec,
   input  logic [ADDR_W-1:0]        up_addr,
   input  logic [DATA_W-1:0]        up_data,
   input  logic [BEN_W-1:0]         up_ben,
   input  logic                     up_timed,
   input  logic [TIME_W-1:0]        up_time,
   output logic [NPORTS-1:0]        dn_wr,
   output logic [NPORTS-1:0]        dn_rd,
   output logic [ADDR_W-1:0]        addr_q,
   output logic [DATA_W*NPORTS-1:0] dn_data,
   output logic [BEN_W*NPORTS-1:0]  dn_ben,
   output logic [NPORTS-1:0]        dn_timed,
   output logic [TIME_W*NPORTS-1:0] dn_time
);
   logic [DATA_W-1:0] data_q;
   logic [BEN_W-1:0]  ben_q;
   logic              timed_q;
   logic [TIME_W-1:0] time_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         dn_wr <= '0;
         dn_rd <= '0;
      end else begin
         dn_wr <= up_wr ? hit_vec : '0;
         dn_rd <= up_rd ? hit_vec : '0;
      end
   end

   // Payload is captured only on a request; it is not reset
   always_ff @(posedge clk) begin
      if (up_wr || up_rd) begin
         addr_q  <= up_addr;
         data_q  <= up_data;
         ben_q   <= up_ben;
         timed_q <= up_timed;
         time_q  <= up_time;
      end
   end

   for (genvar i = 0; i < NPORTS; i++) begin : g_fan
      assign dn_data[i*DATA_W +: DATA_W] = data_q;
      assign dn_ben[i*BEN_W +: BEN_W]    = ben_q;
      assign dn_timed[i]                 = timed_q;
      assign dn_time[i*TIME_W +: TIME_W] = time_q;
   end

   AST_ONE_PORT_WR: assert property (@(posedge clk) disable iff (rst)
      $onehot0(dn_wr)); // R1
   AST_ONE_PORT_RD: assert property (@(posedge clk) disable iff (rst)
      $onehot0(dn_rd)); // R1
   AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
      (!up_wr && !up_rd) |=> (dn_wr == '0 && dn_rd == '0)); // R4
endmodule

// File: rtl/regbus_resp_merge.sv
// Response register: OR of gated slave replies, or a local address-error reply.
module regbus_resp_merge
   import rsplit_pkg::*;
#(
   parameter int NPORTS = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     miss,
   input  logic [NPORTS-1:0]        dn_ack,
   input  logic [STS_W*NPORTS-1:0]  dn_status,
   input  logic [DATA_W*NPORTS-1:0] dn_rdata,
   output logic                     up_ack,
   output logic [STS_W-1:0]         up_status,
   output logic [DATA_W-1:0]        up_rdata
);
   logic              ack_d;
   logic [STS_W-1:0]  sts_d;
   logic [DATA_W-1:0] dat_d;

   always_comb begin
      ack_d = 1'b0;
      sts_d = '0;
      dat_d = '0;
      for (int i = 0; i < NPORTS; i++) begin
         if (dn_ack[i]) begin
            ack_d = 1'b1;
            sts_d = sts_d | dn_status[i*STS_W +: STS_W];
            dat_d = dat_d | dn_rdata[i*DATA_W +: DATA_W];
         end
      end
      if (miss) begin
         ack_d = 1'b1;
         sts_d = STS_ADDR_ERR;
         dat_d = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         up_ack    <= 1'b0;
         up_status <= '0;
         up_rdata  <= '0;
      end else begin
         up_ack    <= ack_d;
         up_status <= sts_d;
         up_rdata  <= dat_d;
      end
   end

   AST_SINGLE_ACK: assert property (@(posedge clk) disable iff (rst)
      $onehot0(dn_ack)); // R5
   AST_ACK_FORWARD: assert property (@(posedge clk) disable iff (rst)
      (|dn_ack) |=> up_ack); // R5
   AST_MISS_REPLY: assert property (@(posedge clk) disable iff (rst)
      miss |=> (up_ack && up_status == STS_ADDR_ERR && up_rdata == '0)); // R6
endmodule

// File: rtl/regbus_splitter.sv
module regbus_splitter
   import rsplit_pkg::*;
#(
   parameter int                         NPORTS     = 4,
   parameter logic [ADDR_W*NPORTS-1:0]   BASE_VEC   = {20'h300, 20'h200, 20'h100, 20'h000},
   parameter logic [32*NPORTS-1:0]       AWIDTH_VEC = {32'd8, 32'd8, 32'd8, 32'd8}
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     up_wr,
   input  logic                     up_rd,
   input  logic [ADDR_W-1:0]        up_addr,
   input  logic [DATA_W-1:0]        up_data,
   input  logic [BEN_W-1:0]         up_ben,
   input  logic                     up_timed,
   input  logic [TIME_W-1:0]        up_time,
   output logic                     up_ack,
   output logic [STS_W-1:0]         up_status,
   output logic [DATA_W-1:0]        up_rdata,
   output logic [NPORTS-1:0]        dn_wr,
   output logic [NPORTS-1:0]        dn_rd,
   output logic [ADDR_W*NPORTS-1:0] dn_addr,
   output logic [DATA_W*NPORTS-1:0] dn_data,
   output logic [BEN_W*NPORTS-1:0]  dn_ben,
   output logic [NPORTS-1:0]        dn_timed,
   output logic [TIME_W*NPORTS-1:0] dn_time,
   input  logic [NPORTS-1:0]        dn_ack,
   input  logic [STS_W*NPORTS-1:0]  dn_status,
   input  logic [DATA_W*NPORTS-1:0] dn_rdata
);
   if (NPORTS < 1) begin : g_bad_count
      $error("at least one port is required");
   end

   // Pairwise overlap check on the windows
   for (genvar i = 0; i < NPORTS; i++) begin : g_ovl_i
      for (genvar j = i + 1; j < NPORTS; j++) begin : g_ovl_j
         localparam longint BI = longint'(BASE_VEC[i*ADDR_W +: ADDR_W]);
         localparam longint BJ = longint'(BASE_VEC[j*ADDR_W +: ADDR_W]);
         localparam longint SI = longint'(1) << AWIDTH_VEC[i*32 +: 6];
         localparam longint SJ = longint'(1) << AWIDTH_VEC[j*32 +: 6];
         if (BI < BJ + SJ && BJ < BI + SI) begin : g_overlap
            $error("windows of ports %0d and %0d overlap", i, j);
         end
      end
   end

   logic [NPORTS-1:0] hit_vec;
   logic [ADDR_W-1:0] addr_q;
   logic              miss;

   for (genvar i = 0; i < NPORTS; i++) begin : g_win
      regbus_window #(
         .BASE (BASE_VEC[i*ADDR_W +: ADDR_W]),
         .AW   (int'(AWIDTH_VEC[i*32 +: 32]))
      ) u_win (
         .req_addr  (up_addr),
         .held_addr (addr_q),
         .hit       (hit_vec[i]),
         .offset    (dn_addr[i*ADDR_W +: ADDR_W])
      );
   end

   assign miss = (up_wr || up_rd) && (hit_vec == '0);

   regbus_req_stage #(.NPORTS(NPORTS)) u_req (
      .clk      (clk),
      .rst      (rst),
      .up_wr    (up_wr),
      .up_rd    (up_rd),
      .hit_vec  (hit_vec),
      .up_addr  (up_addr),
      .up_data  (up_data),
      .up_ben   (up_ben),
      .up_timed (up_timed),
      .up_time  (up_time),
      .dn_wr    (dn_wr),
      .dn_rd    (dn_rd),
      .addr_q   (addr_q),
      .dn_data  (dn_data),
      .dn_ben   (dn_ben),
      .dn_timed (dn_timed),
      .dn_time  (dn_time)
   );

   regbus_resp_merge #(.NPORTS(NPORTS)) u_resp (
      .clk       (clk),
      .rst       (rst),
      .miss      (miss),
      .dn_ack    (dn_ack),
      .dn_status (dn_status),
      .dn_rdata  (dn_rdata),
      .up_ack    (up_ack),
      .up_status (up_status),
      .up_rdata  (up_rdata)
   );

   AST_MISS_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
      miss |=> (dn_wr == '0 && dn_rd == '0)); // R6
   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (dn_wr == '0 && dn_rd == '0 && !up_ack)); // R7
endmodule

// File: tb/regbus_splitter_test.sv
module regbus_splitter_test;
   import rsplit_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NP  = 4;
   localparam int AWB = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic up_wr = 1'b0, up_rd = 1'b0, up_timed = 1'b0;
   logic [ADDR_W-1:0] up_addr = '0;
   logic [DATA_W-1:0] up_data = '0;
   logic [BEN_W-1:0]  up_ben = '0;
   logic [TIME_W-1:0] up_time = '0;
   logic              up_ack;
   logic [STS_W-1:0]  up_status;
   logic [DATA_W-1:0] up_rdata;
   logic [NP-1:0]        dn_wr, dn_rd, dn_timed;
   logic [ADDR_W*NP-1:0] dn_addr;
   logic [DATA_W*NP-1:0] dn_data;
   logic [BEN_W*NP-1:0]  dn_ben;
   logic [TIME_W*NP-1:0] dn_time;
   logic [NP-1:0]        dn_ack = '0;
   logic [STS_W*NP-1:0]  dn_status = '1;
   logic [DATA_W*NP-1:0] dn_rdata = {NP{32'hDEAD_BEEF}};

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   regbus_splitter uut (
      .clk(clk), .rst(rst),
      .up_wr(up_wr), .up_rd(up_rd), .up_addr(up_addr), .up_data(up_data),
      .up_ben(up_ben), .up_timed(up_timed), .up_time(up_time),
      .up_ack(up_ack), .up_status(up_status), .up_rdata(up_rdata),
      .dn_wr(dn_wr), .dn_rd(dn_rd), .dn_addr(dn_addr), .dn_data(dn_data),
      .dn_ben(dn_ben), .dn_timed(dn_timed), .dn_time(dn_time),
      .dn_ack(dn_ack), .dn_status(dn_status), .dn_rdata(dn_rdata)
   );

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic int port_of(logic [ADDR_W-1:0] a);
      for (int k = 0; k < NP; k++)
         if (int'(a) >= k*256 && int'(a) < k*256 + (1 << AWB)) return k;
      return -1;
   endfunction

   task automatic do_req(logic [ADDR_W-1:0] a, bit is_wr);
      int p;
      logic [DATA_W-1:0] rd_exp;
      p = port_of(a);
      @(negedge clk);
      up_wr = is_wr; up_rd = !is_wr; up_addr = a;
      up_data = {12'hA5C, a}; up_ben = a[3:0]; up_timed = a[0];
      up_time = {44'h0, a} ^ 64'h1234_0000_0000_0000;
      @(negedge clk);
      up_wr = 0; up_rd = 0;
      // R1 R4: strobes one clock after the request, only on the hit port
      chk("R1 R4 wr strobes", 64'(dn_wr), (p >= 0 && is_wr) ? 64'(1 << p) : 64'd0);
      chk("R1 R4 rd strobes", 64'(dn_rd), (p >= 0 && !is_wr) ? 64'(1 << p) : 64'd0);
      if (p >= 0) begin
         chk("R2 local offset", 64'(dn_addr[p*ADDR_W +: ADDR_W]), 64'(int'(a) - p*256));
         chk("R3 data", 64'(dn_data[p*DATA_W +: DATA_W]), 64'({12'hA5C, a}));
         chk("R3 ben", 64'(dn_ben[p*BEN_W +: BEN_W]), 64'(a[3:0]));
         chk("R3 timed", 64'(dn_timed[p]), 64'(a[0]));
         chk("R3 time", dn_time[p*TIME_W +: TIME_W], {44'h0, a} ^ 64'h1234_0000_0000_0000);
         chk("R5 no early ack", 64'(up_ack), 64'd0);
         rd_exp = 32'h5A00_0000 ^ {12'h0, a} ^ 32'(p);
         dn_ack[p] = 1'b1;
         dn_status[p*STS_W +: STS_W] = a[5:4];
         dn_rdata[p*DATA_W +: DATA_W] = rd_exp;
         @(negedge clk);
         dn_ack = '0; dn_status = '1; dn_rdata = {NP{32'hDEAD_BEEF}};
         chk("R4 strobe one cycle", 64'(dn_wr | dn_rd), 64'd0);
         chk("R5 ack", 64'(up_ack), 64'd1);
         chk("R5 status", 64'(up_status), 64'(a[5:4]));
         chk("R5 rdata", 64'(up_rdata), 64'(rd_exp));
      end else begin
         chk("R6 ack", 64'(up_ack), 64'd1);
         chk("R6 status", 64'(up_status), 64'(2'b11));
         chk("R6 rdata", 64'(up_rdata), 64'd0);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R7 reset strobes", 64'(dn_wr | dn_rd), 64'd0);
      chk("R7 reset ack", 64'(up_ack), 64'd0);
      rst = 0;

      for (int a = 0; a < 'h500; a++)
         do_req(ADDR_W'(a), a[0] ^ a[8]);
      do_req(20'hFFFFF, 1'b1);
      do_req(20'h80000, 1'b0);
      do_req(20'h40100, 1'b1);

      // R7: request and reset together are dropped
      @(negedge clk);
      up_wr = 1; up_addr = 20'h123; rst = 1;
      @(negedge clk);
      up_wr = 0; rst = 0;
      chk("R7 dropped strobe", 64'(dn_wr | dn_rd), 64'd0);
      @(negedge clk);
      up_rd = 1; up_addr = 20'h9000; rst = 1;
      @(negedge clk);
      up_rd = 0; rst = 0;
      chk("R7 dropped miss ack", 64'(up_ack), 64'd0);
      do_req(20'h2FF, 1'b0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule